// File: doc/BRIEF.md
# Buffered Bulk-Program Controller

This block sequences a buffered bulk-program operation for a NOR-style flash model. Once a start pulse has armed it, bus writes each carry one 16-bit word. The controller gathers 32 words in a write buffer and then copies them into an internal word array one location at a time. It reads back every word it has written and writes it again when the readback does not match.

The first write of the operation fixes the target block and the 32-word slice inside it. Each later write only has to stay inside that block: the bus offset is not used, because the controller steps through array locations itself. After a full buffer has been committed, the next 32 writes fill the next slice of the same block without a new start pulse. The operation ends when a write names another block, or when the last slice of the block has been committed.

A status byte reports three things: busy (the next word cannot be taken yet), done (the controller is back in status-read mode) and a sticky error. Two test inputs force the readback of one chosen array address to fail for a set number of attempts, so the retry path can be exercised.

Top module: `buf_prog_ctrl`

## Requirements
- R1: After reset the status byte is 8'h80 (bit 7 done = 1, bit 4 error = 0, bit 0 busy = 0). A bus write made while done is set is ignored: busy stays 0 and the status stays 8'h80.
- R2: A one-cycle start pulse while done is set arms the controller. From the next cycle the status byte reads 8'h00.
- R3: An accepted write sets busy in the cycle after the write. For words 1 to 31 of a slice, busy clears one cycle later. A write presented while busy is ignored and its data never reaches the array.
- R4: The first write after arming selects the block from address bits [8:5] of the 9-bit address, as follows. Bit 8 is the block number. Bits [7:5] select the 32-word slice. Bits [4:0] are ignored. The first data word goes to slice location 0. Later words fill locations 1 to 31 in order, whatever their offset inside the block.
- R5: After the 32nd write of a slice, busy stays high for 65 cycles when no retry occurs. The 32 array words of the slice then hold the written data in order.
- R6: When a readback mismatches, the word is written again, which adds 2 busy cycles per retry. A word that matches within 4 retries ends holding the correct data, and the error bit stays 0.
- R7: A word that still mismatches after 4 retries sets status bit 4 after 5 attempts (8 extra busy cycles). The array keeps the failed value, which is the data with bit 0 inverted. The commit then continues with the next word.
- R8: After a slice has been committed, the operation stays active (status bit 7 = 0). The next 32 writes to the same block go to the next 32 array locations.
- R9: A write to another block, made while busy is clear, ends the operation. From the next cycle done is 1 and busy is 0. The partly filled buffer is dropped and not written to the array.
- R10: Committing slice 7, the last slice of a block, ends the operation. Done reads 1 as soon as busy clears.
- R11: The error bit stays set after the operation ends and is cleared by the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arms a new operation while done is set |
| wr_en | input | 1 | Bus write strobe, one cycle per word |
| wr_addr | input | 9 | Bus write address (bit 8 block, bits 7:5 slice) |
| wr_data | input | 16 | Bus write data |
| fail_addr | input | 9 | Array address whose readback is forced to fail |
| fail_tries | input | 3 | Number of attempts on fail_addr that are corrupted |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 16 | Array word at rd_addr, combinational |
| status | output | 8 | Bit 7 done, bit 4 error, bit 0 busy |

## Verification
Each accepted write raises busy exactly one cycle later. A data word clears busy after one cycle. The last word of a slice keeps busy high for 65 cycles, plus 2 for each retry. A write to another block sets done in the very next cycle. The bench samples on falling edges and counts busy cycles from the first falling edge after the strobe, comparing the count with these figures. It then reads the array words back only once busy has cleared.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ARMED = 3'd1,
        S_FILL  = 3'd2,
        S_LATCH = 3'd3,
        S_CWR   = 3'd4,
        S_CVF   = 3'd5
    } bfp_state_t;
endpackage

// File: rtl/bfp_wbuf.sv
module bfp_wbuf #(
    parameter int DW = 16,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    localparam int N = 1 << IW;
    logic [DW-1:0] slot_q [N];

    always_ff @(posedge clk) begin
        if (we) slot_q[widx] <= wdata;
    end

    assign rdata = slot_q[ridx];
endmodule

// File: rtl/bfp_array.sv
module bfp_array #(
    parameter int DW = 16,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] vaddr,
    output logic [DW-1:0] vdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    assign vdata = cell_q[vaddr];
    assign rdata = cell_q[raddr];
endmodule

// File: rtl/buf_prog_ctrl.sv
module buf_prog_ctrl
    import bfp_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 9,
    parameter int BLK_W     = 8,
    parameter int BUF_W     = 5,
    parameter int MAX_RETRY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] fail_addr,
    input  logic [2:0]    fail_tries,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [7:0]    status
);
    localparam int BUF_N   = 1 << BUF_W;
    localparam int PH_W    = BLK_W - BUF_W;
    localparam int BID_W   = AW - BLK_W;
    localparam int TRY_W   = 3;
    localparam logic [BUF_W:0]   FULL_CNT = (BUF_W+1)'(BUF_N);
    localparam logic [BUF_W-1:0] LAST_IDX = BUF_W'(BUF_N - 1);
    localparam logic [TRY_W-1:0] TRY_MAX  = TRY_W'(MAX_RETRY);

    typedef struct packed {
        bfp_state_t       state;
        logic [BID_W-1:0] blk;
        logic [PH_W-1:0]  ph;
        logic [BUF_W:0]   cnt;
        logic [BUF_W-1:0] idx;
        logic [TRY_W-1:0] tries;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;

    logic             buf_we;
    logic [BUF_W-1:0] buf_widx;
    logic [DW-1:0]    buf_rdata;
    logic             arr_we;
    logic [AW-1:0]    arr_addr;
    logic [DW-1:0]    arr_wdata;
    logic [DW-1:0]    arr_vdata;
    logic             corrupt;
    logic             mismatch;
    logic [BID_W-1:0] wr_blk;
    logic             busy;

    assign wr_blk    = wr_addr[AW-1:BLK_W];
    assign arr_addr  = {r_q.blk, r_q.ph, r_q.idx};
    assign corrupt   = (arr_addr == fail_addr) && (r_q.tries < fail_tries);
    assign arr_wdata = buf_rdata ^ {{(DW-1){1'b0}}, corrupt};
    assign mismatch  = (arr_vdata != buf_rdata);

    bfp_wbuf #(.DW(DW), .IW(BUF_W)) u_wbuf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (buf_widx),
        .wdata (wr_data),
        .ridx  (r_q.idx),
        .rdata (buf_rdata)
    );

    bfp_array #(.DW(DW), .AW(AW)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_addr),
        .wdata (arr_wdata),
        .vaddr (arr_addr),
        .vdata (arr_vdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_comb begin
        r_d      = r_q;
        buf_we   = 1'b0;
        buf_widx = r_q.cnt[BUF_W-1:0];
        arr_we   = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (start) begin
                    r_d.state = S_ARMED;
                    r_d.err   = 1'b0;
                end
            end
            S_ARMED: begin
                if (wr_en) begin
                    r_d.blk   = wr_blk;
                    r_d.ph    = wr_addr[BLK_W-1:BUF_W];
                    buf_we    = 1'b1;
                    buf_widx  = '0;
                    r_d.cnt   = (BUF_W+1)'(1);
                    r_d.state = S_LATCH;
                end
            end
            S_FILL: begin
                if (wr_en) begin
                    if (wr_blk != r_q.blk) begin
                        r_d.cnt   = '0;
                        r_d.state = S_IDLE;
                    end else begin
                        buf_we    = 1'b1;
                        r_d.cnt   = r_q.cnt + 1'b1;
                        r_d.state = S_LATCH;
                    end
                end
            end
            S_LATCH: begin
                if (r_q.cnt == FULL_CNT) begin
                    r_d.idx   = '0;
                    r_d.tries = '0;
                    r_d.state = S_CWR;
                end else begin
                    r_d.state = S_FILL;
                end
            end
            S_CWR: begin
                arr_we    = 1'b1;
                r_d.state = S_CVF;
            end
            S_CVF: begin
                if (mismatch && (r_q.tries < TRY_MAX)) begin
                    r_d.tries = r_q.tries + 1'b1;
                    r_d.state = S_CWR;
                end else begin
                    if (mismatch) r_d.err = 1'b1;
                    r_d.tries = '0;
                    if (r_q.idx == LAST_IDX) begin
                        r_d.cnt = '0;
                        if (r_q.ph == '1) begin
                            r_d.state = S_IDLE;
                        end else begin
                            r_d.ph    = r_q.ph + 1'b1;
                            r_d.state = S_FILL;
                        end
                    end else begin
                        r_d.idx   = r_q.idx + 1'b1;
                        r_d.state = S_CWR;
                    end
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = (r_q.state == S_LATCH) || (r_q.state == S_CWR) || (r_q.state == S_CVF);
    assign status = {(r_q.state == S_IDLE), 2'b00, r_q.err, 3'b000, busy};

    // A latch cycle always hands over to filling or committing.
    assert_latch_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_LATCH) |=> (r_q.state == S_FILL || r_q.state == S_CWR));

    // The buffer word count never passes the buffer size.
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= FULL_CNT);

    // Every array write is followed by its readback cycle.
    assert_write_then_verify_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_CWR) |=> (r_q.state == S_CVF));

    // The retry counter stays inside its limit.
    assert_retry_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.tries <= TRY_MAX);

    // A write to another block while filling ends the operation at once.
    assert_block_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_FILL && wr_en && wr_blk != r_q.blk) |=> (status[7] && !status[0]));
endmodule

// File: tb/buf_prog_ctrl_test.sv
module buf_prog_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [8:0]  fail_addr = 9'h1FF;
    logic [2:0]  fail_tries = 3'd0;
    logic [8:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [7:0]  status;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    buf_prog_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .fail_addr(fail_addr),
        .fail_tries(fail_tries), .rd_addr(rd_addr), .rd_data(rd_data),
        .status(status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [8:0] a, input logic [15:0] d, output int bc);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        bc = 0;
        while (status[0] && bc < 1000) begin
            bc++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_start;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [8:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(req, {16'h0, rd_data}, {16'h0, exp});
    endtask

    task automatic fill_slice(input logic [8:0] a, input logic [15:0] base, output int bc_last);
        int bc;
        for (int i = 0; i < 32; i++) begin
            bus_wr(a, base + 16'(i), bc);
        end
        bc_last = bc;
    endtask

    task automatic t_reset_idle;
        int bc;
        check("R1 reset status", {24'h0, status}, 32'h80);
        bus_wr(9'h005, 16'h1234, bc);
        check("R1 idle write busy", bc, 0);
        check("R1 idle write status", {24'h0, status}, 32'h80);
    endtask

    task automatic t_arm;
        pulse_start();
        check("R2 armed status", {24'h0, status}, 32'h00);
    endtask

    task automatic t_slice_a;
        int bc;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 9'h013; wr_data = 16'hA000;
        @(negedge clk);
        check("R3 busy after write", {31'h0, status[0]}, 1);
        wr_data = 16'hDEAD;
        @(negedge clk);
        check("R3 busy clears", {31'h0, status[0]}, 0);
        wr_en = 1'b0;
        bus_wr(9'h0FF, 16'hA001, bc);
        check("R3 data word busy cycles", bc, 1);
        for (int i = 2; i < 31; i++) begin
            bus_wr((i % 2) ? 9'h0FF : 9'h013, 16'hA000 + 16'(i), bc);
        end
        bus_wr(9'h040, 16'hA01F, bc);
        check("R5 commit busy cycles", bc, 65);
        check("R8 still active", {24'h0, status}, 32'h00);
        for (int i = 0; i < 32; i++) begin
            rd_check("R4 R5 slice A word", 9'(i), 16'hA000 + 16'(i));
        end
    endtask

    task automatic t_slice_b_retry;
        int bc;
        fail_addr = 9'd35; fail_tries = 3'd2;
        fill_slice(9'h020, 16'hB000, bc);
        check("R6 retry busy cycles", bc, 69);
        check("R6 no error", {24'h0, status}, 32'h00);
        for (int i = 0; i < 32; i++) begin
            rd_check("R6 R8 slice B word", 9'(32 + i), 16'hB000 + 16'(i));
        end
    endtask

    task automatic t_slice_c_error;
        int bc;
        fail_addr = 9'd71; fail_tries = 3'd7;
        fill_slice(9'h0C3, 16'hC000, bc);
        check("R7 exhausted busy cycles", bc, 73);
        check("R7 error status", {24'h0, status}, 32'h10);
        rd_check("R7 failed word kept", 9'd71, 16'hC006);
        rd_check("R7 next word committed", 9'd72, 16'hC008);
        rd_check("R8 slice C first word", 9'd64, 16'hC000);
        fail_tries = 3'd0;
    endtask

    task automatic t_block_exit;
        int bc;
        for (int i = 0; i < 5; i++) begin
            bus_wr(9'h0AA, 16'hD000 + 16'(i), bc);
        end
        bus_wr(9'h100, 16'hEEEE, bc);
        check("R9 exit no busy", bc, 0);
        check("R9 exit status", {24'h0, status}, 32'h90);
        rd_addr = 9'd96;
        #1;
        n_checks++;
        if (rd_data === 16'hD000) begin
            n_fail++;
            $display("FAIL R9 dropped buffer written: actual %h expected not D000", rd_data);
        end
        bus_wr(9'h0AA, 16'h5555, bc);
        check("R11 error kept after exit", {24'h0, status}, 32'h90);
    endtask

    task automatic t_last_slice;
        int bc;
        pulse_start();
        check("R11 start clears error", {24'h0, status}, 32'h00);
        fill_slice(9'h1E5, 16'hF000, bc);
        check("R10 last slice busy cycles", bc, 65);
        check("R10 ends after last slice", {24'h0, status}, 32'h80);
        rd_check("R10 first word", 9'h1E0, 16'hF000);
        rd_check("R10 last word", 9'h1FF, 16'hF01F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_idle();
        t_arm();
        t_slice_a();
        t_slice_b_retry();
        t_slice_c_error();
        t_block_exit();
        t_last_slice();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule